// File: doc/BRIEF.md
# Accuracy-Configurable Windowed Approximate Adder

This block adds two 16-bit unsigned operands with three overlapping 8-bit window adders. The low window covers bits 7:0, the middle window bits 11:4 and the high window bits 15:8. Each upper window starts its add with carry-in zero. It relies on its own lower four bits, which it shares with the window below, to produce the carry into its upper nibble. The approximate 17-bit sum is therefore ready after one short 8-bit add, with no ripple across the full width.

A guessed carry can be too low. This happens when the real carry arriving at the bottom of a window would have rippled through that window's lower nibble. A detect stage finds each such mispredict and passes a flag per upper window down the pipeline. A correct stage then increments the affected upper nibble. A two-bit accuracy mode chosen per operation decides which windows are repaired. Exact mode returns A+B two cycles after acceptance. The fully relaxed mode skips repair and returns the raw windowed sum one cycle after acceptance. Two mixed modes repair only one of the upper windows.

Operands enter through a valid/ready handshake and results leave through another, in the order they were accepted. An error flag travels with each result. It marks a result that differs from the exact sum because a needed repair was skipped.

Top module: `approx_window_adder`

## Requirements
- R1: The raw sum is assembled as follows: bits 7:0 are the low window sum, bits 11:8 are the upper nibble of the middle window sum, bits 15:12 are the upper nibble of the high window sum, and bit 16 is the high window's carry out. Each window adds with carry-in zero.
- R2: With `in_mode` = 2'b00 (exact), `out_sum` equals the 17-bit A+B and `out_err` is 0 for every operand pair.
- R3: When no window mispredicts its carry, every mode returns the exact A+B with `out_err` low. A mispredict in a window means that the true carry into that window's upper nibble is 1 while the carry out of the window's own lower nibble is 0.
- R4: With `in_mode` = 2'b01, only a mispredict in the high window is repaired (bits 16:12 take their exact value). A middle-window mispredict is left in place.
- R5: With `in_mode` = 2'b10, only a mispredict in the middle window is repaired (bits 11:8 take their exact value). A high-window mispredict is left in place.
- R6: With `in_mode` = 2'b11, no repair is made and the raw sum of R1 is returned.
- R7: `out_err` is 1 exactly when the returned `out_sum` differs from the exact A+B.
- R8: A result for mode 2'b11 becomes valid one cycle after its operands are accepted. A result for any other mode becomes valid two cycles after acceptance, provided the output is not stalled.
- R9: While `out_valid` is high and `out_ready` is low, `out_sum` and `out_err` hold steady. `in_ready` falls only while a result is waiting at the output.
- R10: Results leave in acceptance order when modes are mixed, including a one-cycle result that follows a two-cycle result.
- R11: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are presented |
| in_ready | output | 1 | Block accepts operands this cycle |
| in_a | input | 16 | First operand, unsigned |
| in_b | input | 16 | Second operand, unsigned |
| in_mode | input | 2 | Accuracy mode: 00 exact, 01 repair high, 10 repair middle, 11 raw |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | 17 | Sum, bit 16 is the carry out |
| out_err | output | 1 | Result differs from exact A+B |

## Verification
The handshake assertions assume a consumer that does not change its mind about data it has been offered. They also assume reset is held long enough to clear both pipeline slots. The bench drives inputs only at falling edges and samples `in_ready` a moment later, so nothing races against `out_ready`. The sum assertions assume operands are known, two-state values. The stimulus uses only defined operand values, including all-ones carry chains that set both mispredict flags at once, and in the stream test it throttles `out_ready` to force stalls behind two-cycle results.

// File: rtl/awa_pkg.sv
package awa_pkg;

   typedef enum logic [1:0] {
      AM_EXACT   = 2'b00,
      AM_FIX_TOP = 2'b01,
      AM_FIX_LOW = 2'b10,
      AM_RAW     = 2'b11
   } acc_mode_e;

   typedef struct packed {
      logic fix_top;
      logic fix_rest;
   } fix_sel_t;

   // Which upper windows get repaired for a mode
   function automatic fix_sel_t mode_fix(input acc_mode_e m);
      fix_sel_t s;
      unique case (m)
         AM_EXACT:   s = '{fix_top: 1'b1, fix_rest: 1'b1};
         AM_FIX_TOP: s = '{fix_top: 1'b1, fix_rest: 1'b0};
         AM_FIX_LOW: s = '{fix_top: 1'b0, fix_rest: 1'b1};
         default:    s = '{fix_top: 1'b0, fix_rest: 1'b0};
      endcase
      return s;
   endfunction

endpackage

// File: rtl/awa_window.sv
// One speculative upper window: carry-in zero, lower part only feeds the
// carry guess for the upper part.
module awa_window #(
   parameter int WIN_W = 8,
   parameter int OVL_W = 4,
   localparam int STEP = WIN_W - OVL_W
) (
   input  logic [WIN_W-1:0] a_i,
   input  logic [WIN_W-1:0] b_i,
   output logic [STEP-1:0]  hi_o,
   output logic             cout_o,
   output logic             spec_o
);
   localparam logic [OVL_W:0] LO_MAX = {1'b0, {OVL_W{1'b1}}};

   logic [OVL_W:0] a_lo, b_lo;
   logic [STEP:0]  a_hi, b_hi;

   assign a_lo = {1'b0, a_i[OVL_W-1:0]};
   assign b_lo = {1'b0, b_i[OVL_W-1:0]};
   assign a_hi = {1'b0, a_i[WIN_W-1:OVL_W]};
   assign b_hi = {1'b0, b_i[WIN_W-1:OVL_W]};

   // carry out of the shared lower part, taken as the guessed carry
   assign spec_o = (a_lo + b_lo) > LO_MAX;
   assign {cout_o, hi_o} = a_hi + b_hi + {{STEP{1'b0}}, spec_o};

endmodule

// File: rtl/awa_spec_stage.sv
// Builds the raw windowed sum and flags each upper window whose carry guess
// fell short of the true carry.
module awa_spec_stage #(
   parameter int WIN_W   = 8,
   parameter int OVL_W   = 4,
   parameter int NUM_WIN = 3,
   localparam int STEP   = WIN_W - OVL_W,
   localparam int DATA_W = WIN_W + (NUM_WIN - 1) * STEP
) (
   input  logic [DATA_W-1:0]  a_i,
   input  logic [DATA_W-1:0]  b_i,
   output logic [DATA_W:0]    raw_o,
   output logic [NUM_WIN-1:1] mis_o
);
   logic [STEP-1:0]    win_hi [1:NUM_WIN-1];
   logic [NUM_WIN-1:1] win_cout;
   logic [NUM_WIN-1:1] win_spec;
   logic [NUM_WIN-1:1] true_c;   // true carry into window w upper part
   logic               base_cout;

   // low window is exact by itself
   assign {base_cout, raw_o[WIN_W-1:0]} =
      {1'b0, a_i[WIN_W-1:0]} + {1'b0, b_i[WIN_W-1:0]};
   assign true_c[1] = base_cout;

   for (genvar w = 1; w < NUM_WIN; w++) begin : g_win
      localparam int BASE = w * STEP;
      localparam int HPOS = BASE + OVL_W;

      awa_window #(.WIN_W(WIN_W), .OVL_W(OVL_W)) u_win (
         .a_i    (a_i[BASE +: WIN_W]),
         .b_i    (b_i[BASE +: WIN_W]),
         .hi_o   (win_hi[w]),
         .cout_o (win_cout[w]),
         .spec_o (win_spec[w])
      );

      assign raw_o[HPOS +: STEP] = win_hi[w];
      assign mis_o[w] = true_c[w] & ~win_spec[w];

      if (w < NUM_WIN - 1) begin : g_chain
         // a short guess ripples on when the upper part was all ones
         assign true_c[w+1] = win_cout[w] | (mis_o[w] & (&win_hi[w]));
      end else begin : g_top
         assign raw_o[DATA_W] = win_cout[w];
      end
   end

   always_comb begin
      assert_clean_exact_R3: assert ((|mis_o) ||
         (raw_o == ({1'b0, a_i} + {1'b0, b_i})))
         else $error("raw sum wrong without mispredict");
      assert_mis_differs_R7: assert (!(|mis_o) ||
         (raw_o != ({1'b0, a_i} + {1'b0, b_i})))
         else $error("mispredict flagged on an exact raw sum");
   end

endmodule

// File: rtl/awa_fix_stage.sv
// Repairs flagged upper windows allowed by the mode; reports skipped repairs.
module awa_fix_stage
   import awa_pkg::*;
#(
   parameter int WIN_W   = 8,
   parameter int OVL_W   = 4,
   parameter int NUM_WIN = 3,
   localparam int STEP   = WIN_W - OVL_W,
   localparam int DATA_W = WIN_W + (NUM_WIN - 1) * STEP
) (
   input  logic [DATA_W:0]    raw_i,
   input  logic [NUM_WIN-1:1] mis_i,
   input  acc_mode_e          mode_i,
   output logic [DATA_W:0]    sum_o,
   output logic               err_o
);
   fix_sel_t           sel;
   logic [NUM_WIN-1:1] mask;

   assign sel = mode_fix(mode_i);
   assign sum_o[WIN_W-1:0] = raw_i[WIN_W-1:0];

   for (genvar w = 1; w < NUM_WIN; w++) begin : g_fix
      localparam int HPOS = w * STEP + OVL_W;
      logic inc;

      if (w == NUM_WIN - 1) begin : g_top
         assign mask[w] = sel.fix_top;
         assign inc = mis_i[w] & mask[w];
         // top nibble carries into the final carry bit
         assign sum_o[DATA_W:HPOS] = raw_i[DATA_W:HPOS] + (STEP+1)'(inc);
      end else begin : g_mid
         assign mask[w] = sel.fix_rest;
         assign inc = mis_i[w] & mask[w];
         assign sum_o[HPOS +: STEP] = raw_i[HPOS +: STEP] + STEP'(inc);
      end
   end

   assign err_o = |(mis_i & ~mask);

   always_comb begin
      assert_exact_noerr_R2: assert (!(mode_i == AM_EXACT) || !err_o)
         else $error("error raised in exact mode");
   end

endmodule

// File: rtl/awa_pipe_ctrl.sv
// Two-slot control: slot one holds detected results, slot two holds
// repaired results. Raw-mode items leave from slot one only when slot two
// is empty, keeping acceptance order.
module awa_pipe_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic out_ready,
   input  logic s1_bypass,
   output logic in_ready,
   output logic out_valid,
   output logic s1_load,
   output logic s2_load,
   output logic sel_s2
);
   logic s1_v, s2_v;
   logic pop_s2, s1_adv, s1_pop, s1_free;

   assign pop_s2  = s2_v & out_ready;
   assign s1_adv  = s1_v & ~s1_bypass & (~s2_v | pop_s2);
   assign s1_pop  = s1_v & s1_bypass & ~s2_v & out_ready;
   assign s1_free = ~s1_v | s1_adv | s1_pop;

   assign in_ready  = s1_free;
   assign s1_load   = in_valid & s1_free;
   assign s2_load   = s1_adv;
   assign out_valid = s2_v | (s1_v & s1_bypass);
   assign sel_s2    = s2_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v <= 1'b0;
         s2_v <= 1'b0;
      end else begin
         if (s1_load)      s1_v <= 1'b1;
         else if (s1_free) s1_v <= 1'b0;
         if (s1_adv)       s2_v <= 1'b1;
         else if (pop_s2)  s2_v <= 1'b0;
      end
   end

   assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> out_valid)
      else $error("input stalled with nothing waiting at output");

endmodule

// File: rtl/approx_window_adder.sv
module approx_window_adder
   import awa_pkg::*;
#(
   parameter int WIN_W   = 8,
   parameter int OVL_W   = 4,
   parameter int NUM_WIN = 3,
   localparam int STEP   = WIN_W - OVL_W,
   localparam int DATA_W = WIN_W + (NUM_WIN - 1) * STEP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic [1:0]        in_mode,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W:0]   out_sum,
   output logic              out_err
);
   initial begin : elab_chk
      if (OVL_W < 1 || OVL_W >= WIN_W)
         $error("overlap must be at least 1 and below the window width");
      if (NUM_WIN < 2)
         $error("at least two windows are needed");
   end

   logic [DATA_W:0]    det_raw;
   logic [NUM_WIN-1:1] det_mis;

   logic [DATA_W:0]    s1_raw;
   logic [NUM_WIN-1:1] s1_mis;
   acc_mode_e          s1_mode;

   logic [DATA_W:0]    fix_sum;
   logic               fix_err;
   logic [DATA_W:0]    s2_sum;
   logic               s2_err;

   logic s1_load, s2_load, sel_s2;

   awa_spec_stage #(.WIN_W(WIN_W), .OVL_W(OVL_W), .NUM_WIN(NUM_WIN)) u_spec (
      .a_i   (in_a),
      .b_i   (in_b),
      .raw_o (det_raw),
      .mis_o (det_mis)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_raw  <= '0;
         s1_mis  <= '0;
         s1_mode <= AM_EXACT;
      end else if (s1_load) begin
         s1_raw  <= det_raw;
         s1_mis  <= det_mis;
         s1_mode <= acc_mode_e'(in_mode);
      end
   end

   awa_fix_stage #(.WIN_W(WIN_W), .OVL_W(OVL_W), .NUM_WIN(NUM_WIN)) u_fix (
      .raw_i  (s1_raw),
      .mis_i  (s1_mis),
      .mode_i (s1_mode),
      .sum_o  (fix_sum),
      .err_o  (fix_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_sum <= '0;
         s2_err <= 1'b0;
      end else if (s2_load) begin
         s2_sum <= fix_sum;
         s2_err <= fix_err;
      end
   end

   awa_pipe_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .s1_bypass (s1_mode == AM_RAW),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .s1_load   (s1_load),
      .s2_load   (s2_load),
      .sel_s2    (sel_s2)
   );

   assign out_sum = sel_s2 ? s2_sum : fix_sum;
   assign out_err = sel_s2 ? s2_err : fix_err;

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_sum) && $stable(out_err)))
      else $error("stalled result changed");

endmodule

// File: tb/approx_window_adder_bench.sv
module approx_window_adder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_a = '0;
   logic [15:0] in_b = '0;
   logic [1:0]  in_mode = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [16:0] out_sum;
   logic        out_err;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   approx_window_adder u_approx_window_adder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_a(in_a), .in_b(in_b), .in_mode(in_mode), .out_valid(out_valid),
      .out_ready(out_ready), .out_sum(out_sum), .out_err(out_err)
   );

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // {err, sum} from the requirement rules
   function automatic logic [17:0] model(input logic [15:0] a, b,
                                         input logic [1:0] m);
      logic [16:0] exact;
      logic [8:0]  low;
      logic [7:0]  midw;
      logic [8:0]  highw;
      logic        c8, c12, spec8, spec12, mis_m, mis_h, fix_h, fix_m;
      logic [3:0]  n2;
      logic [4:0]  top;
      logic [16:0] s;
      exact  = {1'b0, a} + {1'b0, b};
      low    = {1'b0, a[7:0]} + {1'b0, b[7:0]};
      midw   = a[11:4] + b[11:4];
      highw  = {1'b0, a[15:8]} + {1'b0, b[15:8]};
      c8     = low[8];
      c12    = exact[12] ^ a[12] ^ b[12];
      spec8  = ({1'b0, a[7:4]} + {1'b0, b[7:4]}) > 5'd15;
      spec12 = ({1'b0, a[11:8]} + {1'b0, b[11:8]}) > 5'd15;
      mis_m  = c8 & ~spec8;
      mis_h  = c12 & ~spec12;
      fix_h  = (m == 2'b00) || (m == 2'b01);
      fix_m  = (m == 2'b00) || (m == 2'b10);
      n2  = (mis_m && fix_m) ? exact[11:8]  : midw[7:4];
      top = (mis_h && fix_h) ? exact[16:12] : highw[8:4];
      s   = {top, n2, low[7:0]};
      return {s != exact, s};
   endfunction

   task automatic run_one(input logic [15:0] a, b, input logic [1:0] m,
                          input string req);
      logic [17:0] e;
      int lat;
      e = model(a, b, m);
      @(negedge clk);
      in_a = a; in_b = b; in_mode = m; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      lat = 1;
      while (!out_valid && lat < 6) begin
         @(negedge clk);
         lat++;
      end
      check({req, " sum"}, 32'(out_sum), 32'(e[16:0]));
      check({req, " err"}, 32'(out_err), 32'(e[17]));
      check("R8 latency", lat, (m == 2'b11) ? 1 : 2);
      check("R7 err equals sum mismatch", 32'(out_err),
            32'(out_sum != ({1'b0, a} + {1'b0, b})));
   endtask

   task automatic run_fixed(input logic [15:0] a, b, input logic [1:0] m,
                            input logic [16:0] es, input logic ee,
                            input string req);
      run_one(a, b, m, req);
      check({req, " fixed sum"}, 32'(out_sum), 32'(es));
      check({req, " fixed err"}, 32'(out_err), 32'(ee));
   endtask

   task automatic t_reset;
      check("R11 out_valid after reset", 32'(out_valid), 0);
      check("R11 in_ready after reset", 32'(in_ready), 1);
   endtask

   task automatic t_exact;
      logic [15:0] av [9] = '{16'hffff, 16'hffff, 16'h0000, 16'h0ff8, 16'h00ff,
                              16'h7fff, 16'h8000, 16'h0fff, 16'hfff8};
      logic [15:0] bv [9] = '{16'h0001, 16'hffff, 16'h0000, 16'h0008, 16'h0001,
                              16'h0001, 16'h8000, 16'h0001, 16'h0008};
      for (int i = 0; i < 9; i++) begin
         run_one(av[i], bv[i], 2'b00, "R2 exact");
         check("R2 exact equals a+b", 32'(out_sum),
               32'({1'b0, av[i]} + {1'b0, bv[i]}));
      end
   endtask

   task automatic t_clean;
      for (int m = 0; m < 4; m++) begin
         run_fixed(16'h1234, 16'h4321, 2'(m), 17'h05555, 1'b0, "R3 clean");
         run_fixed(16'h8800, 16'h8800, 2'(m), 17'h11000, 1'b0, "R3 clean");
      end
   endtask

   task automatic t_modes;
      // both upper windows mispredict
      run_fixed(16'h0ff8, 16'h0008, 2'b00, 17'h01000, 1'b0, "R2 both mis");
      run_fixed(16'h0ff8, 16'h0008, 2'b01, 17'h01f00, 1'b1, "R4 both mis");
      run_fixed(16'h0ff8, 16'h0008, 2'b10, 17'h00000, 1'b1, "R5 both mis");
      run_fixed(16'h0ff8, 16'h0008, 2'b11, 17'h00f00, 1'b1, "R6 both mis");
      // middle window only
      run_fixed(16'h00f8, 16'h0008, 2'b01, 17'h00000, 1'b1, "R4 mid mis");
      run_fixed(16'h00f8, 16'h0008, 2'b10, 17'h00100, 1'b0, "R5 mid mis");
      run_fixed(16'h00f8, 16'h0008, 2'b11, 17'h00000, 1'b1, "R6 mid mis");
      // high window only
      run_fixed(16'h0f80, 16'h0080, 2'b01, 17'h01000, 1'b0, "R4 high mis");
      run_fixed(16'h0f80, 16'h0080, 2'b10, 17'h00000, 1'b1, "R5 high mis");
      run_fixed(16'h0f80, 16'h0080, 2'b11, 17'h00000, 1'b1, "R1 high mis raw");
      // carry out of the top window lands in bit 16
      run_fixed(16'hff00, 16'h0100, 2'b11, 17'h10000, 1'b0, "R1 top carry");
      run_fixed(16'hfff8, 16'h0008, 2'b11, 17'h0ff00, 1'b1, "R1 all ones raw");
   endtask

   task automatic t_random;
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a, b;
         a = 16'($urandom);
         b = 16'($urandom);
         if (i % 5 == 0) b = ~a + 16'(i % 3);
         run_one(a, b, 2'(i % 4), "R7 random");
      end
   endtask

   task automatic t_hold;
      logic [17:0] ea, eb;
      ea = model(16'h0ff8, 16'h0008, 2'b00);
      eb = model(16'h0ff8, 16'h0008, 2'b11);
      @(negedge clk);
      out_ready = 1'b0;
      in_a = 16'h0ff8; in_b = 16'h0008; in_mode = 2'b00; in_valid = 1'b1;
      @(negedge clk);
      in_mode = 2'b11;
      check("R9 slot free for second item", 32'(in_ready), 1);
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 in_ready low while blocked", 32'(in_ready), 0);
      check("R9 first result offered", 32'(out_valid), 1);
      check("R9 first result sum", 32'(out_sum), 32'(ea[16:0]));
      repeat (3) @(negedge clk);
      check("R9 held sum", 32'(out_sum), 32'(ea[16:0]));
      check("R9 held err", 32'(out_err), 32'(ea[17]));
      check("R9 still blocked", 32'(in_ready), 0);
      out_ready = 1'b1;
      @(negedge clk);
      check("R10 second after first", 32'(out_sum), 32'(eb[16:0]));
      check("R10 second err", 32'(out_err), 32'(eb[17]));
      @(negedge clk);
      check("R10 drained", 32'(out_valid), 0);
   endtask

   task automatic t_stream;
      localparam int N = 32;
      logic [15:0] sa [N];
      logic [15:0] sb [N];
      logic [1:0]  sm [N];
      logic [17:0] ex [N];
      for (int i = 0; i < N; i++) begin
         sa[i] = (i % 3 == 0) ? 16'h0ff8 : 16'($urandom);
         sb[i] = (i % 3 == 0) ? 16'h0008 : 16'($urandom);
         sm[i] = 2'((i * 7 + i / 4) % 4);
         ex[i] = model(sa[i], sb[i], sm[i]);
      end
      fork
         begin
            int idx = 0;
            while (idx < N) begin
               @(negedge clk);
               in_a = sa[idx]; in_b = sb[idx]; in_mode = sm[idx];
               in_valid = 1'b1;
               #1;
               if (in_ready) idx++;
            end
            @(negedge clk);
            in_valid = 1'b0;
         end
         begin
            int got = 0;
            int guard = 0;
            while (got < N && guard < 2000) begin
               @(negedge clk);
               guard++;
               out_ready = ($urandom % 4) != 0;
               if (out_valid && out_ready) begin
                  check("R10 stream sum", 32'(out_sum), 32'(ex[got][16:0]));
                  check("R10 stream err", 32'(out_err), 32'(ex[got][17]));
                  got++;
               end
            end
            check("R10 stream count", got, N);
            out_ready = 1'b1;
         end
      join
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R8 actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_exact();
      t_clean();
      t_modes();
      t_random();
      t_hold();
      t_stream();
      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule